// File: doc/BRIEF.md
# Comparator Output Change Interrupt and Wake Controller

This block collects the digital outputs of several analog comparator-style buffers, one per amplifier channel, and turns their changes of state into interrupt and wake-up events. Each raw output is asynchronous to the bus clock. It is brought through a synchronizer and shown to software as a status bit. Any rising or falling edge of that synchronized value is an event for the channel. Per-channel enables decide which events are recorded, and a chip power-down input changes the recording rules.

Software programs the block through an APB-style register port with two words. The control word holds four per-channel enable groups: amplifier enable, digital buffer enable, interrupt enable and wake-up enable. The status word holds three per-channel groups: synchronized output, interrupt flag and wake-up flag. Software clears flags by writing 1s. The block drives one level interrupt request and one level wake-up request to the rest of the chip. The amplifier enable bits are only stored and driven out on `amp_en` for the analog macro.

Top module: `cmp_evt_wake_ctrl`

## Requirements
- R1: The control word sits at offset 0x00. Channel i has its amplifier enable at bit i, its buffer enable at bit 4+i, its interrupt enable at bit 8+i and its wake-up enable at bit 12+i. All other bits read as 0 and ignore writes. `amp_en` mirrors the amplifier enable bits.
- R2: The status word sits at offset 0x04. Bit i is channel i's synchronized output. It follows the raw input after two rising clock edges and reads 0 whenever that channel's buffer enable is 0. Writes to these bits have no effect.
- R3: A change of the status bit caused only by the buffer enable switching on or off is not an event and sets no flag.
- R4: Outside power-down (`chip_pd` = 0), every rising or falling edge of an enabled channel's output sets its interrupt flag (status bit 4+i). The flag is visible on the third rising clock edge after the raw input changes.
- R5: In power-down, an edge sets the interrupt flag only if that channel's wake-up enable is 1.
- R6: The wake-up flag (status bit 8+i) is set by an edge only when `chip_pd` = 1 and the channel's wake-up enable is 1.
- R7: `irq` is 1 exactly when some channel has both its interrupt flag and its interrupt enable set.
- R8: `wake_req` is 1 exactly when any wake-up flag is set.
- R9: Writing 1 to a flag bit of the status word clears that flag. Writing 0 leaves it unchanged.
- R10: When a hardware set and a software clear hit the same flag at the same clock edge, the flag ends up set.
- R11: After reset, all control bits, flags, `irq` and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data (0 when not selected) |
| buf_dout_raw | input | NUM_CH | Asynchronous buffer outputs, one per channel |
| chip_pd | input | 1 | Chip power-down indication |
| amp_en | output | NUM_CH | Stored amplifier enables |
| irq | output | 1 | Combined interrupt request |
| wake_req | output | 1 | Combined wake-up request |

## Verification
A raw input change reaches the status bit after two rising edges. The flags, `irq` and `wake_req` follow on the third edge. Register writes take effect at the edge that ends the access phase. The bench changes inputs on falling edges and holds a status read open. It then checks the status word one and two falling edges after a toggle, which shows the synchronizer depth, and checks the flags and requests on the third falling edge. The set-against-clear case is built by placing a clearing write's access edge on exactly the third edge after a toggle.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
   // spacing between per-channel field groups in both words
   localparam int FIELD_STRIDE = 4;
   // control word field groups
   localparam int CTL_AMP_LSB  = 0;
   localparam int CTL_BUF_LSB  = 1 * FIELD_STRIDE;
   localparam int CTL_IEN_LSB  = 2 * FIELD_STRIDE;
   localparam int CTL_WKE_LSB  = 3 * FIELD_STRIDE;
   // status word field groups
   localparam int ST_DOUT_LSB  = 0;
   localparam int ST_IFL_LSB   = 1 * FIELD_STRIDE;
   localparam int ST_WFL_LSB   = 2 * FIELD_STRIDE;
   localparam int MIN_DATA_W   = 4 * FIELD_STRIDE;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cmp_evt_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("cmp_evt_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_evt_chan.sv
module cmp_evt_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic buf_en,
   input  logic wke,
   input  logic pd,
   input  logic ifl_clr,
   input  logic wfl_clr,
   output logic dout,
   output logic ifl,
   output logic wfl
);
   logic prev_q, en_q, ifl_q, wfl_q;
   logic edge_hit, ifl_set, wfl_set;

   // status value is forced low while the buffer is off
   assign dout     = sync_in & buf_en;
   // an edge counts only if the buffer was on in both compared cycles
   assign edge_hit = buf_en & en_q & (dout ^ prev_q);
   assign ifl_set  = edge_hit & (~pd | wke);
   assign wfl_set  = edge_hit & pd & wke;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         en_q   <= 1'b0;
         ifl_q  <= 1'b0;
         wfl_q  <= 1'b0;
      end else begin
         prev_q <= dout;
         en_q   <= buf_en;
         // hardware set has priority over the software clear
         ifl_q  <= ifl_set | (ifl_q & ~ifl_clr);
         wfl_q  <= wfl_set | (wfl_q & ~wfl_clr);
      end
   end

   assign ifl = ifl_q;
   assign wfl = wfl_q;

   assert_enable_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(buf_en) && !ifl_q && !wfl_q) |=> (!ifl_q && !wfl_q));
   assert_pd_needs_wke_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ifl_q) && ifl_q) |-> (!$past(pd) || $past(wke)));
   assert_wake_only_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wfl_q) && wfl_q) |-> ($past(pd) && $past(wke)));
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ifl_set |=> ifl_q);
   assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ifl_clr && !ifl_set) |=> !ifl_q);
endmodule

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
   import cmp_evt_pkg::*;
#(
   parameter int          NUM_CH   = 3,
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter logic [7:0]  CTRL_OFS = 8'h00,
   parameter logic [7:0]  STAT_OFS = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic [NUM_CH-1:0] st_dout,
   input  logic [NUM_CH-1:0] st_ifl,
   input  logic [NUM_CH-1:0] st_wfl,
   output logic [NUM_CH-1:0] amp_en,
   output logic [NUM_CH-1:0] buf_en,
   output logic [NUM_CH-1:0] ien,
   output logic [NUM_CH-1:0] wke,
   output logic [NUM_CH-1:0] ifl_clr,
   output logic [NUM_CH-1:0] wfl_clr
);
   generate
      if (NUM_CH < 1 || NUM_CH > FIELD_STRIDE) begin : g_bad_ch
         $error("cmp_evt_regs: NUM_CH must lie in 1..FIELD_STRIDE");
      end
      if (DATA_W < MIN_DATA_W) begin : g_bad_data
         $error("cmp_evt_regs: DATA_W too narrow for the field groups");
      end
      if (ADDR_W > 8 || ADDR_W < 3) begin : g_bad_addr
         $error("cmp_evt_regs: ADDR_W must lie in 3..8");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] CTRL_A = CTRL_OFS[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] STAT_A = STAT_OFS[ADDR_W-1:0];

   reg_sel_e sel;
   logic     wr_commit;
   logic [NUM_CH-1:0] amp_q, buf_q, ien_q, wke_q;
   logic     unused_wdata;

   always_comb begin
      if (paddr == CTRL_A)      sel = SEL_CTRL;
      else if (paddr == STAT_A) sel = SEL_STAT;
      else                      sel = SEL_NONE;
   end

   assign wr_commit = psel & penable & pwrite;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amp_q <= '0;
         buf_q <= '0;
         ien_q <= '0;
         wke_q <= '0;
      end else if (wr_commit && sel == SEL_CTRL) begin
         amp_q <= pwdata[CTL_AMP_LSB +: NUM_CH];
         buf_q <= pwdata[CTL_BUF_LSB +: NUM_CH];
         ien_q <= pwdata[CTL_IEN_LSB +: NUM_CH];
         wke_q <= pwdata[CTL_WKE_LSB +: NUM_CH];
      end
   end

   assign ifl_clr = (wr_commit && sel == SEL_STAT) ? pwdata[ST_IFL_LSB +: NUM_CH] : '0;
   assign wfl_clr = (wr_commit && sel == SEL_STAT) ? pwdata[ST_WFL_LSB +: NUM_CH] : '0;

   always_comb begin
      prdata = '0;
      if (psel && sel == SEL_CTRL) begin
         prdata[CTL_AMP_LSB +: NUM_CH] = amp_q;
         prdata[CTL_BUF_LSB +: NUM_CH] = buf_q;
         prdata[CTL_IEN_LSB +: NUM_CH] = ien_q;
         prdata[CTL_WKE_LSB +: NUM_CH] = wke_q;
      end else if (psel && sel == SEL_STAT) begin
         prdata[ST_DOUT_LSB +: NUM_CH] = st_dout;
         prdata[ST_IFL_LSB  +: NUM_CH] = st_ifl;
         prdata[ST_WFL_LSB  +: NUM_CH] = st_wfl;
      end
   end

   assign unused_wdata = ^pwdata;
   assign amp_en = amp_q;
   assign buf_en = buf_q;
   assign ien    = ien_q;
   assign wke    = wke_q;

   assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_commit && sel == SEL_CTRL) |=> $stable(ien_q) && $stable(wke_q));
endmodule

// File: rtl/cmp_evt_wake_ctrl.sv
module cmp_evt_wake_ctrl #(
   parameter int         NUM_CH      = 3,
   parameter int         SYNC_STAGES = 2,
   parameter int         ADDR_W      = 8,
   parameter int         DATA_W      = 32,
   parameter logic [7:0] CTRL_OFS    = 8'h00,
   parameter logic [7:0] STAT_OFS    = 8'h04
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic [NUM_CH-1:0] buf_dout_raw,
   input  logic              chip_pd,
   output logic [NUM_CH-1:0] amp_en,
   output logic              irq,
   output logic              wake_req
);
   logic [NUM_CH-1:0] sync_v, dout_v, ifl_v, wfl_v;
   logic [NUM_CH-1:0] buf_en, ien, wke, ifl_clr, wfl_clr;

   cmp_evt_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (pclk),
      .rst_n(presetn),
      .d    (buf_dout_raw),
      .q    (sync_v)
   );

   cmp_evt_regs #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
   ) u_regs (
      .clk    (pclk),
      .rst_n  (presetn),
      .psel   (psel),
      .penable(penable),
      .pwrite (pwrite),
      .paddr  (paddr),
      .pwdata (pwdata),
      .prdata (prdata),
      .st_dout(dout_v),
      .st_ifl (ifl_v),
      .st_wfl (wfl_v),
      .amp_en (amp_en),
      .buf_en (buf_en),
      .ien    (ien),
      .wke    (wke),
      .ifl_clr(ifl_clr),
      .wfl_clr(wfl_clr)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         cmp_evt_chan u_chan (
            .clk    (pclk),
            .rst_n  (presetn),
            .sync_in(sync_v[c]),
            .buf_en (buf_en[c]),
            .wke    (wke[c]),
            .pd     (chip_pd),
            .ifl_clr(ifl_clr[c]),
            .wfl_clr(wfl_clr[c]),
            .dout   (dout_v[c]),
            .ifl    (ifl_v[c]),
            .wfl    (wfl_v[c])
         );
      end
   endgenerate

   assign irq      = |(ifl_v & ien);
   assign wake_req = |wfl_v;

   assert_irq_needs_enable_R7: assert property (@(posedge pclk) disable iff (!presetn)
      irq |-> (ien != '0));
   assert_wake_from_pd_R8: assert property (@(posedge pclk) disable iff (!presetn)
      $rose(wake_req) |-> $past(chip_pd));
   assert_status_off_R2: assert property (@(posedge pclk) disable iff (!presetn)
      (buf_en == '0) |-> (dout_v == '0));
endmodule

// File: tb/cmp_evt_wake_ctrl_bench.sv
`timescale 1ns/1ps
module cmp_evt_wake_ctrl_bench;
   localparam int NCH = 3;
   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_STAT = 8'h04;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [NCH-1:0] raw_v = '0;
   logic        chip_pd = 1'b0;
   logic [NCH-1:0] amp_en;
   logic        irq, wake_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cmp_evt_wake_ctrl u_cmp_evt_wake_ctrl (
      .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .buf_dout_raw(raw_v), .chip_pd(chip_pd), .amp_en(amp_en),
      .irq(irq), .wake_req(wake_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0; pwdata = '0;
   endtask

   task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge clk); penable = 1; #1 d = prdata;
      psel = 0; penable = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #3_000_000;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11: reset state
      apb_rd(A_CTRL, rd); chk("R11 ctrl", rd, 32'h0);
      apb_rd(A_STAT, rd); chk("R11 stat", rd, 32'h0);
      chk("R11 irq", {31'd0, irq}, 32'd0);
      chk("R11 wake", {31'd0, wake_req}, 32'd0);
      chk("R11 amp_en", {29'd0, amp_en}, 32'd0);

      // R1: field layout and reserved bits
      apb_wr(A_CTRL, 32'hFFFF_FFFF);
      apb_rd(A_CTRL, rd); chk("R1 ctrl readback", rd, 32'h0000_7777);
      chk("R1 amp_en", {29'd0, amp_en}, 32'h7);
      apb_wr(A_CTRL, 32'h0000_2501);
      apb_rd(A_CTRL, rd); chk("R1 ctrl pattern", rd, 32'h0000_2501);
      // R2: status output bits ignore writes (raw is 0, buffers off)
      apb_wr(A_STAT, 32'hFFFF_FFFF);
      apb_rd(A_STAT, rd); chk("R2 stat write ignored", rd, 32'h0);
      apb_wr(A_CTRL, 32'h0);

      // sweep: channel x {buf, ien, wke, pd}
      for (int ch = 0; ch < NCH; ch++) begin
         for (int cfg = 0; cfg < 16; cfg++) begin
            logic b, ie, wk, pd, old_bit, new_bit, e_if, e_wf;
            logic [31:0] ctl, exp_st;
            b = cfg[0]; ie = cfg[1]; wk = cfg[2]; pd = cfg[3];
            ctl = (32'(b) << (4 + ch)) | (32'(ie) << (8 + ch)) |
                  (32'(wk) << (12 + ch)) | (32'd1 << ch);
            apb_wr(A_CTRL, ctl);
            chip_pd = pd;
            apb_wr(A_STAT, 32'h0000_0770);
            old_bit = raw_v[ch];
            new_bit = ~old_bit;
            psel = 1; penable = 0; pwrite = 0; paddr = A_STAT;
            raw_v[ch] = new_bit;
            @(negedge clk);
            chk("R2 status before sync depth", prdata, 32'(b & old_bit) << ch);
            @(negedge clk);
            chk("R2 status after two edges", prdata, 32'(b & new_bit) << ch);
            @(negedge clk);
            e_if = b & (~pd | wk);   // R4 / R5
            e_wf = b & pd & wk;      // R6
            exp_st = (32'(b & new_bit) << ch) | (32'(e_if) << (4 + ch)) |
                     (32'(e_wf) << (8 + ch));
            if (pd) chk("R5 flags in power-down", prdata, exp_st);
            else    chk("R4 flags out of power-down", prdata, exp_st);
            chk("R6 wake flag", {31'd0, prdata[8 + ch]}, {31'd0, e_wf});
            chk("R7 irq", {31'd0, irq}, {31'd0, e_if & ie});
            chk("R8 wake_req", {31'd0, wake_req}, {31'd0, e_wf});
            psel = 0;
         end
      end
      chip_pd = 0;
      apb_wr(A_CTRL, 32'h0);
      apb_wr(A_STAT, 32'h0000_0770);

      // R3: buffer switching on with input high is not an event
      raw_v = 3'b001;
      repeat (4) @(negedge clk);
      apb_wr(A_CTRL, 32'h0000_0110);
      repeat (4) @(negedge clk);
      apb_rd(A_STAT, rd); chk("R3 enable no event", rd, 32'h1);
      chk("R3 irq quiet", {31'd0, irq}, 32'd0);
      apb_wr(A_CTRL, 32'h0);
      repeat (4) @(negedge clk);
      apb_rd(A_STAT, rd); chk("R3 disable no event", rd, 32'h0);

      // R9: write-1-to-clear, write-0 keeps
      apb_wr(A_CTRL, 32'h0000_0110);
      @(negedge clk); raw_v[0] = 1'b0;
      repeat (4) @(negedge clk);
      apb_rd(A_STAT, rd); chk("R9 flag raised", rd, 32'h10);
      apb_wr(A_STAT, 32'h0000_0000);
      apb_rd(A_STAT, rd); chk("R9 write 0 keeps", rd, 32'h10);
      chk("R7 irq with flag", {31'd0, irq}, 32'd1);
      apb_wr(A_STAT, 32'h0000_0010);
      apb_rd(A_STAT, rd); chk("R9 write 1 clears", rd, 32'h0);
      chk("R7 irq after clear", {31'd0, irq}, 32'd0);

      // R10: set and clear at the same edge
      @(negedge clk);
      raw_v[0] = 1'b1;
      psel = 1; penable = 0; pwrite = 1; paddr = A_STAT; pwdata = 32'h10;
      @(negedge clk);
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0; pwdata = '0;
      apb_rd(A_STAT, rd); chk("R10 set wins", rd, 32'h11);

      finish_run();
   end
endmodule